// File: doc/BRIEF.md
# Auxiliary Accumulator Register Bank

This unit sits beside the ALU of an 8-bit accumulator processor. It holds four private byte-wide scratch registers and runs single-byte, implied-mode accumulator instructions against them, with no memory operand. The surrounding core decodes the instruction. It then presents an operation code, a 2-bit register index, the live accumulator and the live carry flag. In the same cycle the unit returns the new accumulator value and the processor status bits N, Z, C and V. Each of these outputs comes with its own update enable.

The operations are OR, AND, exclusive-OR, add with carry, subtract with borrow, compare, load to the accumulator and store from the accumulator. Every result and flag is combinational from the inputs and the current register contents. Only a store changes state, and it lands on the next rising clock edge. Each instruction makes a dummy read at the program counter and leaves the counter where it is. That bus activity belongs to the host core's sequencer and is not part of this unit.

Top module: `aux_acc_bank`

## Requirements
- R1: A synchronous active-high reset clears all four registers to 0x00. A load from any register after reset returns 0x00 with Z set and N clear.
- R2: A store (op code 8) writes acc_in into the selected register on the next rising edge. During a store, acc_we, nz_we, c_we and v_we are all 0.
- R3: A load (op code 7) drives acc_out with the selected register's value and asserts acc_we and nz_we. N is bit 7 of the value and Z is set when the value is 0x00. c_we and v_we stay 0.
- R4: OR (op 1), AND (op 2) and exclusive-OR (op 3) drive acc_out with acc_in combined with the selected register. They assert acc_we and nz_we, set N and Z from the result, and leave c_we and v_we at 0.
- R5: Add with carry (op 4) gives acc_out = acc_in + register + carry_in, modulo 256. C is the carry out of bit 7 and V flags signed overflow. All four enables are asserted.
- R6: Subtract with borrow (op 5) gives acc_out = acc_in + ~register + carry_in, modulo 256. C set means no borrow, and V flags signed overflow. All four enables are asserted.
- R7: Compare (op 6) leaves acc_we at 0 and v_we at 0, and asserts nz_we and c_we. C is set when acc_in >= register (unsigned). Z is set when they are equal. N is bit 7 of (acc_in - register) modulo 256.
- R8: When op_valid is 0, or the op code is 0 or above 8, every enable is 0, acc_out equals acc_in, and no register changes.
- R9: reg_sel values 0, 1, 2 and 3 select registers J, K, L and M. A store changes only the selected register and leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies op_code this cycle |
| op_code | input | 4 | Operation: 1 OR, 2 AND, 3 XOR, 4 ADC, 5 SBC, 6 CMP, 7 load, 8 store |
| reg_sel | input | 2 | Register index: 0 J, 1 K, 2 L, 3 M |
| acc_in | input | 8 | Current accumulator value |
| carry_in | input | 1 | Current carry flag |
| acc_out | output | 8 | Next accumulator value (equals acc_in when not written) |
| acc_we | output | 1 | Accumulator update enable |
| n_out | output | 1 | Negative flag value |
| z_out | output | 1 | Zero flag value |
| c_out | output | 1 | Carry flag value |
| v_out | output | 1 | Overflow flag value |
| nz_we | output | 1 | N and Z update enable |
| c_we | output | 1 | C update enable |
| v_we | output | 1 | V update enable |

## Verification
The only hidden state is the four registers. A wrong value in one of them, from a misdirected store, a missed reset or a write to a neighbour, does not show until an instruction reads that register. The first such load, logic or arithmetic operation then shows the error in acc_out and the flags, in the same cycle. The bench therefore follows every store with operations that read all four registers, so that a corruption is exposed within a few cycles of the faulty write. Enable mistakes, such as a compare that writes the accumulator or a store that touches flags, show at the ports in the cycle of the offending operation.

// File: rtl/aux_pkg.sv
package aux_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NUM_REG = 4;
    localparam int unsigned SEL_W   = $clog2(NUM_REG);
    localparam int unsigned OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        AOP_NONE = 4'd0,
        AOP_OR   = 4'd1,
        AOP_AND  = 4'd2,
        AOP_XOR  = 4'd3,
        AOP_ADC  = 4'd4,
        AOP_SBC  = 4'd5,
        AOP_CMP  = 4'd6,
        AOP_LD   = 4'd7,
        AOP_ST   = 4'd8
    } aux_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flag_t;

    typedef struct packed {
        logic acc;
        logic nz;
        logic c;
        logic v;
        logic st;
    } wen_t;

    function automatic wen_t op_enables(aux_op_e op);
        wen_t e;
        e = '0;
        case (op)
            AOP_OR, AOP_AND, AOP_XOR, AOP_LD: begin
                e.acc = 1'b1;
                e.nz  = 1'b1;
            end
            AOP_ADC, AOP_SBC: begin
                e.acc = 1'b1;
                e.nz  = 1'b1;
                e.c   = 1'b1;
                e.v   = 1'b1;
            end
            AOP_CMP: begin
                e.nz = 1'b1;
                e.c  = 1'b1;
            end
            AOP_ST:  e.st = 1'b1;
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/aux_regfile.sv
module aux_regfile
    import aux_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned N     = NUM_REG,
    localparam int unsigned SW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && sel == SW'(i))
                regs[i] <= wdata;
        end

        AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !($past(we) && $past(sel) == SW'(i))) |-> $stable(regs[i])); // R9

        AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> regs[i] == '0); // R1
    end

    assign rdata = regs[sel];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we)) |-> regs[$past(sel)] == $past(wdata)); // R2

endmodule

// File: rtl/aux_alu.sv
module aux_alu
    import aux_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  aux_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output flag_t        flg
);

    logic [W-1:0] opnd;
    logic [W:0]   sum;
    logic [W:0]   diff;

    always_comb begin
        opnd = (op == AOP_SBC) ? ~b : b;
        sum  = {1'b0, a} + {1'b0, opnd} + {{W{1'b0}}, cin};
        diff = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        case (op)
            AOP_OR:           res = a | b;
            AOP_AND:          res = a & b;
            AOP_XOR:          res = a ^ b;
            AOP_ADC, AOP_SBC: res = sum[W-1:0];
            AOP_CMP:          res = diff[W-1:0];
            AOP_LD:           res = b;
            default:          res = a;
        endcase
        flg.n = res[W-1];
        flg.z = (res == '0);
        flg.c = (op == AOP_CMP) ? diff[W] : sum[W];
        flg.v = (a[W-1] == opnd[W-1]) && (res[W-1] != a[W-1]);
    end

endmodule

// File: rtl/aux_acc_bank.sv
module aux_acc_bank
    import aux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_we,
    output logic              n_out,
    output logic              z_out,
    output logic              c_out,
    output logic              v_out,
    output logic              nz_we,
    output logic              c_we,
    output logic              v_we
);

    aux_op_e           op;
    wen_t              en;
    logic [DATA_W-1:0] rd;
    logic [DATA_W-1:0] res;
    flag_t             flg;

    assign op = aux_op_e'(op_code);
    assign en = op_valid ? op_enables(op) : '0;

    aux_regfile #(.W(DATA_W), .N(NUM_REG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (en.st),
        .sel   (reg_sel),
        .wdata (acc_in),
        .rdata (rd)
    );

    aux_alu #(.W(DATA_W)) u_alu (
        .op  (op),
        .a   (acc_in),
        .b   (rd),
        .cin (carry_in),
        .res (res),
        .flg (flg)
    );

    assign acc_out = en.acc ? res : acc_in;
    assign acc_we  = en.acc;
    assign nz_we   = en.nz;
    assign c_we    = en.c;
    assign v_we    = en.v;
    assign n_out   = flg.n;
    assign z_out   = flg.z;
    assign c_out   = flg.c;
    assign v_out   = flg.v;

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd6) |-> (!acc_we && acc_out == acc_in && !v_we)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!acc_we && !nz_we && !c_we && !v_we && acc_out == acc_in)); // R8

    AST_STORE_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd8) |-> !(acc_we || nz_we || c_we || v_we)); // R2

    AST_LOGIC_Z: assert property (@(posedge clk) disable iff (rst)
        (acc_we && !c_we) |-> (z_out == (acc_out == '0) && n_out == acc_out[7])); // R4

endmodule

// File: tb/sim_aux_acc_bank.sv
`timescale 1ns/1ps
module sim_aux_acc_bank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [1:0] reg_sel = '0;
    logic [7:0] acc_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] acc_out;
    logic       acc_we, n_out, z_out, c_out, v_out, nz_we, c_we, v_we;

    int tests = 0;
    int fails = 0;
    int mreg [4];
    bit done = 0;

    always #2.5 clk = ~clk;

    aux_acc_bank u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .reg_sel(reg_sel), .acc_in(acc_in), .carry_in(carry_in),
        .acc_out(acc_out), .acc_we(acc_we), .n_out(n_out), .z_out(z_out),
        .c_out(c_out), .v_out(v_out), .nz_we(nz_we), .c_we(c_we), .v_we(v_we)
    );

    function automatic string tag_of(bit valid, int op);
        if (!valid || op == 0 || op > 8) return "R8";
        case (op)
            1, 2, 3: return "R4";
            4:       return "R5";
            5:       return "R6";
            6:       return "R7";
            7:       return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic run_op(input bit valid, input int op, input int sel,
                          input int a, input int cin, input string tag);
        int b, res, sum, opnd;
        bit eacc, enz, ec, ev, n, z, c, v, bad;
        @(negedge clk);
        op_valid = valid; op_code = 4'(op); reg_sel = 2'(sel);
        acc_in = 8'(a); carry_in = cin[0];
        #1;
        b = mreg[sel];
        eacc = 0; enz = 0; ec = 0; ev = 0; res = a; c = 0; v = 0;
        if (valid) begin
            case (op)
                1: begin res = a | b; eacc = 1; enz = 1; end
                2: begin res = a & b; eacc = 1; enz = 1; end
                3: begin res = a ^ b; eacc = 1; enz = 1; end
                4, 5: begin
                    opnd = (op == 5) ? (255 - b) : b;
                    sum = a + opnd + cin;
                    res = sum % 256;
                    c = sum > 255;
                    v = ((a ^ res) & (opnd ^ res) & 128) != 0;
                    eacc = 1; enz = 1; ec = 1; ev = 1;
                end
                6: begin enz = 1; ec = 1; c = (a >= b); end
                7: begin res = b; eacc = 1; enz = 1; end
                default: ;
            endcase
        end
        if (op == 6 && valid) begin
            n = (((a - b) & 255) >= 128);
            z = (a == b);
        end else begin
            n = res >= 128;
            z = res == 0;
        end
        bad = (acc_we !== eacc) || (nz_we !== enz) || (c_we !== ec) || (v_we !== ev)
              || (acc_out !== 8'(res));
        if (enz && (n_out !== n || z_out !== z)) bad = 1;
        if (ec && c_out !== c) bad = 1;
        if (ev && v_out !== v) bad = 1;
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s op=%0d sel=%0d a=%h: got acc=%h we=%b%b%b%b nzcv=%b%b%b%b exp acc=%h we=%b%b%b%b nzcv=%b%b%b%b",
                     tag, op, sel, a[7:0], acc_out, acc_we, nz_we, c_we, v_we,
                     n_out, z_out, c_out, v_out, res[7:0], eacc, enz, ec, ev, n, z, c, v);
        end
        @(posedge clk);
        if (valid && op == 8) mreg[sel] = a;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        foreach (mreg[i]) mreg[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: every register reads zero after reset
        for (int s = 0; s < 4; s++) run_op(1, 7, s, 8'h5A, 0, "R1");
        // R2 / R9: distinct stores, then read all four back
        run_op(1, 8, 0, 8'h11, 0, "R2");
        run_op(1, 8, 1, 8'h80, 1, "R2");
        run_op(1, 8, 2, 8'h00, 0, "R9");
        run_op(1, 8, 3, 8'hF0, 0, "R9");
        for (int s = 0; s < 4; s++) run_op(1, 7, s, 8'h33, 0, "R9");
        run_op(1, 8, 2, 8'h7F, 0, "R2");
        for (int s = 0; s < 4; s++) run_op(1, 7, s, 8'h00, 0, "R3");
        // R4 logic ops
        run_op(1, 1, 0, 8'h00, 0, "R4");
        run_op(1, 2, 3, 8'h0F, 0, "R4");
        run_op(1, 3, 3, 8'hF0, 0, "R4");
        run_op(1, 1, 1, 8'h01, 0, "R4");
        // R5 add with carry
        run_op(1, 4, 2, 8'h01, 0, "R5");
        run_op(1, 4, 1, 8'h80, 0, "R5");
        run_op(1, 4, 3, 8'h0F, 1, "R5");
        // R6 subtract with borrow
        run_op(1, 5, 2, 8'h50, 1, "R6");
        run_op(1, 5, 0, 8'h80, 1, "R6");
        run_op(1, 5, 0, 8'h11, 0, "R6");
        // R7 compare: equal, above, below
        run_op(1, 6, 0, 8'h11, 0, "R7");
        run_op(1, 6, 0, 8'hFF, 0, "R7");
        run_op(1, 6, 3, 8'h10, 1, "R7");
        // R8: disabled store and unused codes leave registers untouched
        run_op(0, 8, 1, 8'hAA, 0, "R8");
        run_op(1, 0, 1, 8'hAB, 0, "R8");
        run_op(1, 12, 1, 8'hAC, 1, "R8");
        run_op(1, 15, 2, 8'hAD, 1, "R8");
        for (int s = 0; s < 4; s++) run_op(1, 7, s, 8'h00, 0, "R8");
        // mixed random traffic against the model
        for (int k = 0; k < 600; k++) begin
            int op, vld;
            op  = $urandom_range(0, 10);
            vld = ($urandom_range(0, 7) != 0);
            run_op(vld[0], op, $urandom_range(0, 3), $urandom_range(0, 255),
                   $urandom_range(0, 1), tag_of(vld[0], op));
        end
        // reset again clears all registers
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        foreach (mreg[i]) mreg[i] = 0;
        @(negedge clk) rst = 1'b0;
        for (int s = 0; s < 4; s++) run_op(1, 7, s, 8'h99, 0, "R1");
        finish_run();
    end

endmodule